// File: doc/BRIEF.md
# VLIW Slot Legality Decoder

This block screens five-slot very long instruction words before they issue. Each word holds one operation field per slot, and the slot's position fixes which functional-unit class may run there. The decoder sorts each field into an operation class and checks that class against the slot's allow list. It then raises a per-slot fault flag and a whole-bundle illegal flag, and drives one dispatch enable per slot.

There is no compression. A slot with no work must hold an explicit no-operation. An illegal bundle dispatches nothing, so later stages only ever see bundles that obey the slot rules. Results are registered and appear one clock after the bundle is presented with `valid_i` high.

Top module: `vliw_slot_check`

## Requirements
- R1: Slot k (k = 0..4, where slot 1 is k = 0) occupies `bundle_i[8k+7:8k]`. The outputs for a bundle sampled at a rising edge with `valid_i` high appear after that edge, with `valid_o` high.
- R2: Opcode classes are as follows. 0x00 is a no-operation. Top three bits 000 (nonzero) mark integer, 001 mark branch, 010 mark load and 011 mark store. Top bits 100 mark single-precision FP when bit 4 is 0, and 101 mark multiply when bit 4 is 0.
- R3: The allowed classes per slot are: slot 1 integer or branch, slot 2 integer or load, slot 3 load or store, slot 4 FP, slot 5 multiply.
- R4: Opcodes with top bits 100 and bit 4 set (double precision), with top bits 101 and bit 4 set (divide), or with top bits 110 or 111 (undefined) are illegal in every slot.
- R5: A no-operation is legal in every slot and is never dispatched. An all-nop bundle is legal and dispatches no slot.
- R6: A bundle carries at most one branch, and only in slot 1. A branch in any other slot is flagged as a fault of that slot.
- R7: `slot_err_o[k]` is high exactly when slot k holds an operation not allowed there by R3, R4 or R6.
- R8: `illegal_o` is high when any slot faults, and then `dispatch_o` is all zero.
- R9: In a legal bundle, `dispatch_o[k]` is high exactly for the slots holding a non-nop operation.
- R10: A cycle sampled with `valid_i` low yields `valid_o`, `illegal_o`, `slot_err_o` and `dispatch_o` all low.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bundle present this cycle |
| bundle_i | input | 40 | Five 8-bit operation fields, slot 1 in the low byte |
| valid_o | output | 1 | Registered result valid |
| dispatch_o | output | 5 | Per-slot issue enable |
| slot_err_o | output | 5 | Per-slot class fault |
| illegal_o | output | 1 | Bundle rejected |

## Verification
Every one of the 256 opcode values is placed alone in each slot, with nops in the other four. This sweep separates the class decode, including the precision and divide bit, from the slot allow lists. Next, ten representative opcodes, one per class plus the two unsupported kinds and an undefined one, are combined in all 100000 five-slot arrangements. These show that a single bad slot blocks the dispatch of otherwise legal neighbours, and that second branches are rejected. Reset, the all-nop bundle and bundles presented with `valid_i` low are run separately, so that a quiet output can be told apart from a rejected bundle.

// File: rtl/vliw_slot_pkg.sv
package vliw_slot_pkg;

  typedef enum logic [2:0] {
    CL_NOP = 3'd0,
    CL_INT = 3'd1,
    CL_BR  = 3'd2,
    CL_LD  = 3'd3,
    CL_ST  = 3'd4,
    CL_FP  = 3'd5,
    CL_MUL = 3'd6,
    CL_BAD = 3'd7
  } op_cls_e;

  localparam int unsigned NCLS = 8;

  // allow masks, one bit per class (bit index = class code), slot 1 lowest
  localparam logic [7:0] ALLOW_S1 = 8'h06; // int | branch
  localparam logic [7:0] ALLOW_S2 = 8'h0A; // int | load
  localparam logic [7:0] ALLOW_S3 = 8'h18; // load | store
  localparam logic [7:0] ALLOW_S4 = 8'h20; // fp
  localparam logic [7:0] ALLOW_S5 = 8'h40; // multiply
  localparam logic [39:0] DEF_ALLOW = {ALLOW_S5, ALLOW_S4, ALLOW_S3, ALLOW_S2, ALLOW_S1};

endpackage

// File: rtl/slot_op_classify.sv
module slot_op_classify
  import vliw_slot_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0] op_i,
  output op_cls_e         cls_o
);
  localparam int unsigned EXT_BIT = OP_W - 4;

  logic [2:0] grp;
  assign grp = op_i[OP_W-1 -: 3];

  always_comb begin
    cls_o = CL_BAD;
    if (op_i == '0) begin
      cls_o = CL_NOP;
    end else begin
      case (grp)
        3'd0:    cls_o = CL_INT;
        3'd1:    cls_o = CL_BR;
        3'd2:    cls_o = CL_LD;
        3'd3:    cls_o = CL_ST;
        3'd4:    cls_o = op_i[EXT_BIT] ? CL_BAD : CL_FP;  // double precision rejected
        3'd5:    cls_o = op_i[EXT_BIT] ? CL_BAD : CL_MUL; // divide rejected
        default: cls_o = CL_BAD;
      endcase
    end
  end
endmodule

// File: rtl/slot_legal_chk.sv
module slot_legal_chk
  import vliw_slot_pkg::*;
#(
  parameter logic [NCLS-1:0] ALLOW = '0
) (
  input  op_cls_e cls_i,
  output logic    ok_o,
  output logic    is_op_o,
  output logic    is_br_o
);
  always_comb begin
    is_op_o = (cls_i != CL_NOP);
    is_br_o = (cls_i == CL_BR);
    ok_o    = !is_op_o || ((cls_i != CL_BAD) && ALLOW[cls_i]);
  end
endmodule

// File: rtl/bundle_gate.sv
module bundle_gate #(
  parameter int unsigned N_SLOTS = 5,
  parameter int unsigned MAX_BR  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N_SLOTS-1:0] ok_i,
  input  logic [N_SLOTS-1:0] is_op_i,
  input  logic [N_SLOTS-1:0] is_br_i,
  output logic               valid_o,
  output logic [N_SLOTS-1:0] dispatch_o,
  output logic [N_SLOTS-1:0] slot_err_o,
  output logic               illegal_o
);
  localparam int unsigned CNT_W = $clog2(N_SLOTS + 1);

  logic [CNT_W-1:0]   br_cnt;
  logic               br_over;
  logic [N_SLOTS-1:0] err_d;
  logic               ill_d;

  always_comb begin
    br_cnt = '0;
    for (int k = 0; k < N_SLOTS; k++) br_cnt = br_cnt + CNT_W'(is_br_i[k]);
  end

  assign br_over = (32'(br_cnt) > MAX_BR);
  assign err_d   = ~ok_i;
  assign ill_d   = (|err_d) || br_over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      dispatch_o <= '0;
      slot_err_o <= '0;
      illegal_o  <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      slot_err_o <= valid_i ? err_d : '0;
      illegal_o  <= valid_i && ill_d;
      dispatch_o <= (valid_i && !ill_d) ? is_op_i : '0;
    end
  end
endmodule

// File: rtl/vliw_slot_check.sv
module vliw_slot_check
  import vliw_slot_pkg::*;
#(
  parameter int unsigned           N_SLOTS    = 5,
  parameter int unsigned           OP_W       = 8,
  parameter int unsigned           MAX_BR     = 1,
  parameter logic [N_SLOTS*NCLS-1:0] SLOT_ALLOW = DEF_ALLOW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [N_SLOTS*OP_W-1:0] bundle_i,
  output logic                    valid_o,
  output logic [N_SLOTS-1:0]      dispatch_o,
  output logic [N_SLOTS-1:0]      slot_err_o,
  output logic                    illegal_o
);
  logic [N_SLOTS-1:0] ok, is_op, is_br;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    op_cls_e cls;

    slot_op_classify #(.OP_W(OP_W)) u_cls (
      .op_i  (bundle_i[k*OP_W +: OP_W]),
      .cls_o (cls)
    );

    slot_legal_chk #(.ALLOW(SLOT_ALLOW[k*NCLS +: NCLS])) u_chk (
      .cls_i   (cls),
      .ok_o    (ok[k]),
      .is_op_o (is_op[k]),
      .is_br_o (is_br[k])
    );
  end

  bundle_gate #(.N_SLOTS(N_SLOTS), .MAX_BR(MAX_BR)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .ok_i       (ok),
    .is_op_i    (is_op),
    .is_br_i    (is_br),
    .valid_o    (valid_o),
    .dispatch_o (dispatch_o),
    .slot_err_o (slot_err_o),
    .illegal_o  (illegal_o)
  );
endmodule

// File: rtl/vliw_slot_check_sva.sv
module vliw_slot_check_sva #(
  parameter int unsigned N_SLOTS = 5,
  parameter int unsigned OP_W    = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [N_SLOTS*OP_W-1:0] bundle_i,
  input logic                    valid_o,
  input logic [N_SLOTS-1:0]      dispatch_o,
  input logic [N_SLOTS-1:0]      slot_err_o,
  input logic                    illegal_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_valid_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  assert_nop_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(bundle_i[OP_W-1:0]) == '0) |-> !dispatch_o[0]);

  assert_err_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_err_o) |-> illegal_o);

  assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (dispatch_o == '0));

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_o & slot_err_o) == '0);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (dispatch_o == '0 && slot_err_o == '0 && !illegal_o));
endmodule

bind vliw_slot_check vliw_slot_check_sva #(.N_SLOTS(N_SLOTS), .OP_W(OP_W)) u_sva (.*);

// File: tb/vliw_slot_check_tb.sv
module vliw_slot_check_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [39:0] bundle_i = '0;
  logic        valid_o;
  logic [4:0]  dispatch_o, slot_err_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i; // 250 MHz

  vliw_slot_check u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .bundle_i(bundle_i),
    .valid_o(valid_o), .dispatch_o(dispatch_o), .slot_err_o(slot_err_o),
    .illegal_o(illegal_o)
  );

  // class codes: 0 nop 1 int 2 br 3 ld 4 st 5 fp 6 mul 7 bad
  function automatic int cls_of(logic [7:0] op);
    int g = int'(op) / 32;
    int x = (int'(op) / 16) % 2;
    if (op == 8'h00) return 0;
    if (g <= 3) return g + 1;
    if (g == 4) return x ? 7 : 5;
    if (g == 5) return x ? 7 : 6;
    return 7;
  endfunction

  function automatic bit allowed(int s, int c);
    if (c == 0) return 1'b1;
    case (s)
      0: return (c == 1) || (c == 2);
      1: return (c == 1) || (c == 3);
      2: return (c == 3) || (c == 4);
      3: return (c == 5);
      4: return (c == 6);
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [39:0] b, input logic v, input string tag);
    logic [4:0] e_err, e_disp;
    logic       e_ill;
    @(negedge clk_i);
    bundle_i = b;
    valid_i  = v;
    @(posedge clk_i);
    #1;
    e_err = '0;
    e_disp = '0;
    for (int s = 0; s < 5; s++) begin
      int c = cls_of(b[s*8 +: 8]);
      e_err[s]  = v && !allowed(s, c);
      e_disp[s] = (c != 0);
    end
    e_ill  = |e_err;
    e_disp = (v && !e_ill) ? e_disp : 5'b0;
    n_chk++;
    if (valid_o !== v || slot_err_o !== e_err || illegal_o !== e_ill || dispatch_o !== e_disp) begin
      n_bad++;
      $display("FAIL %s bundle=%h act v=%b err=%b ill=%b disp=%b exp v=%b err=%b ill=%b disp=%b",
               tag, b, valid_o, slot_err_o, illegal_o, dispatch_o, v, e_err, e_ill, e_disp);
    end
  endtask

  localparam logic [7:0] REPS [10] = '{8'h00, 8'h07, 8'h23, 8'h41, 8'h62,
                                       8'h85, 8'hA3, 8'h95, 8'hB1, 8'hC0};

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11: reset state
    #7;
    n_chk++;
    if (valid_o !== 1'b0 || dispatch_o !== 5'b0 || slot_err_o !== 5'b0 || illegal_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset act v=%b disp=%b err=%b ill=%b exp all zero",
               valid_o, dispatch_o, slot_err_o, illegal_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: all-nop bundle is legal and dispatches nothing
    apply(40'h0, 1'b1, "R5 all-nop");

    // R10: valid low keeps outputs quiet, even for illegal content
    apply({8'h23, 8'h95, 8'h23, 8'h23, 8'h07}, 1'b0, "R10 idle");
    apply({8'hA3, 8'h85, 8'h62, 8'h41, 8'h23}, 1'b0, "R10 idle");

    // R1/R2/R4/R7: each opcode alone in each slot
    for (int s = 0; s < 5; s++)
      for (int op = 0; op < 256; op++)
        apply(40'(op) << (8 * s), 1'b1, "R1/R2/R4/R7 sweep");

    // R3/R6/R8/R9: all combinations of class representatives
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 10; c++)
          for (int d = 0; d < 10; d++)
            for (int e = 0; e < 10; e++)
              apply({REPS[e], REPS[d], REPS[c], REPS[b], REPS[a]}, 1'b1, "R3/R6/R8/R9 combo");

    // R6: second branch outside slot 1
    apply({8'h00, 8'h00, 8'h00, 8'h23, 8'h23}, 1'b1, "R6 two branches");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule